// File: doc/BRIEF.md
# Per-Rank DRAM Refresh Controller

This block keeps every rank of a multi-rank DRAM channel refreshed on its own schedule. Each rank owns an interval counter, advanced by that rank's refresh-due tick, and a small state machine. When the interval expires, the rank is withdrawn from the scheduler. One cycle later its bank-open status is sampled. If any bank is open, a precharge-all command is requested and the tRP window is waited out; then the refresh command is requested and the rank stays blocked until tRFC has elapsed.

All ranks share one command output with a valid/ready handshake. Among ranks that are requesting at the same time, the lowest-numbered rank wins. While one rank refreshes, every other rank keeps its availability signal, so the read/write scheduler can keep the data bus busy with those ranks. A per-rank power state (idle, active, refresh) is reported so that time spent refreshing is never seen as idle time with all banks closed.

Top module: `rank_refresh_ctrl`

## Requirements
- R1: Each rank counts its own `ref_tick` pulses; idle cycles between ticks do not count. The edge that samples the REFI_TICKS-th tick since reset (or since the previous expiry) drops that rank's `rank_avail` bit right after that edge. Earlier ticks leave it high.
- R2: A rank's `rank_avail` stays low from the refresh-due edge until its refresh wait has finished. A rank whose power state reads refresh is never available.
- R3: If any of the rank's `bank_open` bits is set in the cycle after the due edge, the rank requests a precharge-all (`cmd_op` = 2'b01, `cmd_rank` = the rank). Once that is accepted, the refresh request (`cmd_op` = 2'b10) appears exactly T_RP cycles later, with no refresh request in between.
- R4: If no bank of the rank is open in the cycle after the due edge, the refresh command (`cmd_op` = 2'b10) is requested directly in that cycle's successor, with no precharge.
- R5: After the refresh command is accepted (`cmd_valid` and `cmd_ready` high at an edge), the rank's `rank_avail` rises exactly T_RFC cycles later.
- R6: A refresh on one rank leaves the `rank_avail` bits of all other ranks unchanged.
- R7: When several ranks request at once, `cmd_rank` is the lowest-numbered requester. A request that is not accepted stays asserted in the next cycle.
- R8: `rank_pwr[2r+1:2r]` reads 2'b10 (refresh) from the refresh request until the end of the tRFC wait. Otherwise it reads 2'b01 (active) when any bank of the rank is open, and 2'b00 (idle) when none is.
- R9: An interval that expires while the rank is already busy is remembered. The extra refresh starts on the first edge after the rank returns to idle, so `rank_avail` is high for exactly one cycle in between.
- R10: After reset all `rank_avail` bits are high, `cmd_valid` is low and all interval counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | NUM_RANKS | Per-rank refresh interval tick |
| bank_open | input | NUM_RANKS*BANKS_PER_RANK | Open-bank flags; rank r uses bits [r*BANKS_PER_RANK +: BANKS_PER_RANK] |
| cmd_ready | input | 1 | Command bus accepts the presented command |
| cmd_valid | output | 1 | A precharge-all or refresh command is presented |
| cmd_op | output | 2 | 2'b01 precharge-all, 2'b10 refresh |
| cmd_rank | output | RANK_W | Target rank of the presented command |
| rank_avail | output | NUM_RANKS | Rank may receive read/write traffic |
| rank_pwr | output | 2*NUM_RANKS | Per-rank power state: 00 idle, 01 active, 10 refresh |

## Verification
All sixteen open-bank patterns of one rank are swept through a full refresh. This separates the direct-refresh path (no bank open) from the precharge-first path (any single bank or mix open), and it confirms the tRP and tRFC spacing for each pattern. Ticks with idle gaps show that the interval counts ticks rather than cycles. Interval expiry during an ongoing refresh covers the remembered, back-to-back case. Two ranks expiring together with the bus stalled show both the fixed priority and the holding of a request that has not been accepted.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef enum logic [2:0] {
        RS_IDLE     = 3'd0,
        RS_CHECK    = 3'd1,
        RS_REQ_PRE  = 3'd2,
        RS_WAIT_RP  = 3'd3,
        RS_REQ_REF  = 3'd4,
        RS_WAIT_RFC = 3'd5
    } rank_state_e;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_PREA = 2'b01,
        CMD_REF  = 2'b10
    } cmd_op_e;

    typedef enum logic [1:0] {
        PWR_IDLE    = 2'b00,
        PWR_ACTIVE  = 2'b01,
        PWR_REFRESH = 2'b10
    } pwr_e;

    typedef struct packed {
        logic    req;
        cmd_op_e op;
    } rank_req_t;

    function automatic int unsigned width_of(input int unsigned v);
        return (v <= 1) ? 1 : $clog2(v);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rrc_interval.sv
module rrc_interval
    import rrc_pkg::*;
#(
    parameter int unsigned REFI_TICKS = 7800
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic take,
    output logic due
);
    localparam int unsigned CW = width_of(REFI_TICKS);
    localparam logic [CW-1:0] LAST = CW'(REFI_TICKS - 1);

    logic [CW-1:0] count;
    logic          owed;
    logic          expire;

    assign expire = tick && (count == LAST);
    assign due    = owed || expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            owed  <= 1'b0;
        end else begin
            if (tick) begin
                count <= expire ? '0 : count + 1'b1;
            end
            owed <= due && !take;
        end
    end
endmodule

// File: rtl/rrc_rank_fsm.sv
module rrc_rank_fsm
    import rrc_pkg::*;
#(
    parameter int unsigned BANKS = 8,
    parameter int unsigned T_RP  = 15,
    parameter int unsigned T_RFC = 280
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             due,
    input  logic [BANKS-1:0] bank_open,
    input  logic             grant,
    output rank_req_t        request,
    output logic             is_idle,
    output pwr_e             pwr
);
    localparam int unsigned TW = width_of(max2(T_RP, T_RFC) + 1);
    localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP);
    localparam logic [TW-1:0] RFC_LOAD = TW'(T_RFC);

    rank_state_e   state;
    logic [TW-1:0] timer;
    logic          any_open;
    logic          timer_done;

    assign any_open   = |bank_open;
    assign timer_done = (timer <= TW'(1));
    assign is_idle    = (state == RS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
            timer <= '0;
        end else begin
            case (state)
                RS_IDLE: begin
                    if (due) state <= RS_CHECK;
                end
                RS_CHECK: begin
                    state <= any_open ? RS_REQ_PRE : RS_REQ_REF;
                end
                RS_REQ_PRE: begin
                    if (grant) begin
                        state <= RS_WAIT_RP;
                        timer <= RP_LOAD;
                    end
                end
                RS_WAIT_RP: begin
                    if (timer_done) state <= RS_REQ_REF;
                    else            timer <= timer - 1'b1;
                end
                RS_REQ_REF: begin
                    if (grant) begin
                        state <= RS_WAIT_RFC;
                        timer <= RFC_LOAD;
                    end
                end
                RS_WAIT_RFC: begin
                    if (timer_done) state <= RS_IDLE;
                    else            timer <= timer - 1'b1;
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        request.req = 1'b0;
        request.op  = CMD_NOP;
        if (state == RS_REQ_PRE) begin
            request.req = 1'b1;
            request.op  = CMD_PREA;
        end else if (state == RS_REQ_REF) begin
            request.req = 1'b1;
            request.op  = CMD_REF;
        end
    end

    always_comb begin
        if (state == RS_REQ_REF || state == RS_WAIT_RFC) pwr = PWR_REFRESH;
        else if (any_open)                              pwr = PWR_ACTIVE;
        else                                            pwr = PWR_IDLE;
    end
endmodule

// File: rtl/rrc_cmd_arbiter.sv
module rrc_cmd_arbiter
    import rrc_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  rank_req_t [N-1:0]       requests,
    input  logic                    cmd_ready,
    output logic                    cmd_valid,
    output cmd_op_e                 cmd_op,
    output logic [width_of(N)-1:0]  cmd_rank,
    output logic [N-1:0]            grant
);
    localparam int unsigned RW = width_of(N);

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = CMD_NOP;
        cmd_rank  = '0;
        grant     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (requests[i].req) begin
                cmd_valid = 1'b1;
                cmd_op    = requests[i].op;
                cmd_rank  = RW'(i);
            end
        end
        if (cmd_valid && cmd_ready) begin
            grant[cmd_rank] = 1'b1;
        end
    end
endmodule

// File: rtl/rank_refresh_ctrl.sv
module rank_refresh_ctrl
    import rrc_pkg::*;
#(
    parameter int unsigned NUM_RANKS      = 4,
    parameter int unsigned BANKS_PER_RANK = 8,
    parameter int unsigned T_RP           = 15,
    parameter int unsigned T_RFC          = 280,
    parameter int unsigned REFI_TICKS     = 7800,
    localparam int unsigned RANK_W        = width_of(NUM_RANKS)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_RANKS-1:0]                ref_tick,
    input  logic [NUM_RANKS*BANKS_PER_RANK-1:0] bank_open,
    input  logic                                cmd_ready,
    output logic                                cmd_valid,
    output logic [1:0]                          cmd_op,
    output logic [RANK_W-1:0]                   cmd_rank,
    output logic [NUM_RANKS-1:0]                rank_avail,
    output logic [2*NUM_RANKS-1:0]              rank_pwr
);
    rank_req_t [NUM_RANKS-1:0] rank_req;
    logic      [NUM_RANKS-1:0] rank_grant;
    logic      [NUM_RANKS-1:0] rank_due;
    logic      [NUM_RANKS-1:0] rank_idle;
    cmd_op_e                   arb_op;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        pwr_e pwr_r;

        rrc_interval #(
            .REFI_TICKS(REFI_TICKS)
        ) i_interval (
            .clk (clk),
            .rst (rst),
            .tick(ref_tick[r]),
            .take(rank_idle[r]),
            .due (rank_due[r])
        );

        rrc_rank_fsm #(
            .BANKS(BANKS_PER_RANK),
            .T_RP (T_RP),
            .T_RFC(T_RFC)
        ) i_fsm (
            .clk      (clk),
            .rst      (rst),
            .due      (rank_due[r]),
            .bank_open(bank_open[r*BANKS_PER_RANK +: BANKS_PER_RANK]),
            .grant    (rank_grant[r]),
            .request  (rank_req[r]),
            .is_idle  (rank_idle[r]),
            .pwr      (pwr_r)
        );

        assign rank_avail[r]       = rank_idle[r];
        assign rank_pwr[2*r +: 2]  = pwr_r;
    end

    rrc_cmd_arbiter #(
        .N(NUM_RANKS)
    ) i_arb (
        .requests (rank_req),
        .cmd_ready(cmd_ready),
        .cmd_valid(cmd_valid),
        .cmd_op   (arb_op),
        .cmd_rank (cmd_rank),
        .grant    (rank_grant)
    );

    assign cmd_op = arb_op;
endmodule

// File: rtl/rank_refresh_ctrl_chk.sv
module rank_refresh_ctrl_chk #(
    parameter int unsigned NUM_RANKS      = 4,
    parameter int unsigned BANKS_PER_RANK = 8,
    parameter int unsigned RANK_W         = 2
) (
    input logic                                clk,
    input logic                                rst,
    input logic [NUM_RANKS*BANKS_PER_RANK-1:0] bank_open,
    input logic                                cmd_ready,
    input logic                                cmd_valid,
    input logic [1:0]                          cmd_op,
    input logic [RANK_W-1:0]                   cmd_rank,
    input logic [NUM_RANKS-1:0]                rank_avail,
    input logic [2*NUM_RANKS-1:0]              rank_pwr,
    input logic [NUM_RANKS-1:0]                req_bits
);
    logic [NUM_RANKS-1:0] below_mask;
    assign below_mask = (NUM_RANKS'(1) << cmd_rank) - NUM_RANKS'(1);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid);

    assert_prio_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ((req_bits & below_mask) == '0) && req_bits[cmd_rank]);

    assert_op_legal_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op == 2'b01 || cmd_op == 2'b10));

    assert_ref_closed_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 2'b10 |->
            bank_open[cmd_rank*BANKS_PER_RANK +: BANKS_PER_RANK] == '0);

    assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&rank_avail) && !cmd_valid);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
        assert_refresh_blocks_R2: assert property (@(posedge clk) disable iff (rst)
            rank_pwr[2*r +: 2] == 2'b10 |-> !rank_avail[r]);

        assert_no_early_return_R2: assert property (@(posedge clk) disable iff (rst)
            $fell(rank_avail[r]) |=> !rank_avail[r]);

        assert_pwr_legal_R8: assert property (@(posedge clk) disable iff (rst)
            rank_pwr[2*r +: 2] != 2'b11);
    end
endmodule

bind rank_refresh_ctrl rank_refresh_ctrl_chk #(
    .NUM_RANKS     (NUM_RANKS),
    .BANKS_PER_RANK(BANKS_PER_RANK),
    .RANK_W        (RANK_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bank_open (bank_open),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_rank  (cmd_rank),
    .rank_avail(rank_avail),
    .rank_pwr  (rank_pwr),
    .req_bits  ({rank_req[3].req, rank_req[2].req, rank_req[1].req, rank_req[0].req})
);

// File: tb/test_rank_refresh_ctrl.sv
module test_rank_refresh_ctrl;
    localparam int NR   = 4;
    localparam int NB   = 4;
    localparam int TRP  = 3;
    localparam int TRFC = 8;
    localparam int REFI = 5;
    localparam int RW   = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NR-1:0]       ref_tick = '0;
    logic [NR*NB-1:0]    bank_open = '0;
    logic                cmd_ready = 1'b1;
    logic                cmd_valid;
    logic [1:0]          cmd_op;
    logic [RW-1:0]       cmd_rank;
    logic [NR-1:0]       rank_avail;
    logic [2*NR-1:0]     rank_pwr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rank_refresh_ctrl #(
        .NUM_RANKS(NR), .BANKS_PER_RANK(NB), .T_RP(TRP),
        .T_RFC(TRFC), .REFI_TICKS(REFI)
    ) i_rank_refresh_ctrl (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bank_open(bank_open),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rank(cmd_rank), .rank_avail(rank_avail), .rank_pwr(rank_pwr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_others(input int r);
        for (int o = 0; o < NR; o++) begin
            if (o != r) chk(rank_avail[o] == 1'b1, "R6", "other rank avail", int'(rank_avail[o]), 1);
        end
    endtask

    // Drive REFI ticks to rank r with idle gaps; returns right after the due edge.
    task automatic run_ticks(input int r);
        for (int k = 0; k < REFI; k++) begin
            ref_tick[r] = 1'b1;
            step();
            ref_tick[r] = 1'b0;
            if (k < REFI - 1) begin
                chk(rank_avail[r] == 1'b1, "R1", "avail before interval end", int'(rank_avail[r]), 1);
                step();
                chk(rank_avail[r] == 1'b1, "R1", "avail across idle gap", int'(rank_avail[r]), 1);
            end
        end
    endtask

    // Starts right after the due edge of rank r.
    task automatic finish_refresh(input int r, input logic [NB-1:0] mask, input bit owe);
        int exp_op;
        chk(rank_avail[r] == 1'b0, "R1", "avail after interval end", int'(rank_avail[r]), 0);
        chk(cmd_valid == 1'b0, "R4", "no command in sampling cycle", int'(cmd_valid), 0);
        chk_others(r);
        step();
        exp_op = (mask != '0) ? 1 : 2;
        chk(cmd_valid && int'(cmd_rank) == r, "R3", "request rank", int'(cmd_rank), r);
        chk(int'(cmd_op) == exp_op, (mask != '0) ? "R3" : "R4", "first op", int'(cmd_op), exp_op);
        if (mask != '0) begin
            chk(rank_pwr[2*r +: 2] == 2'b01, "R8", "active while banks open", int'(rank_pwr[2*r +: 2]), 1);
            step();
            bank_open[r*NB +: NB] = '0;
            for (int i = 1; i <= TRP; i++) begin
                step();
                chk(cmd_valid == (i == TRP), "R3", "refresh after tRP", int'(cmd_valid), int'(i == TRP));
                chk(rank_avail[r] == 1'b0, "R2", "blocked during tRP", int'(rank_avail[r]), 0);
            end
            chk(int'(cmd_op) == 2, "R3", "op after precharge", int'(cmd_op), 2);
        end
        chk(rank_pwr[2*r +: 2] == 2'b10, "R8", "refresh power at request", int'(rank_pwr[2*r +: 2]), 2);
        step();
        for (int i = 1; i <= TRFC; i++) begin
            ref_tick[r] = owe && (i <= REFI);
            step();
            ref_tick[r] = 1'b0;
            chk(rank_avail[r] == (i == TRFC), "R5", "avail after tRFC", int'(rank_avail[r]), int'(i == TRFC));
            if (i < TRFC)
                chk(rank_pwr[2*r +: 2] == 2'b10, "R8", "refresh power in wait", int'(rank_pwr[2*r +: 2]), 2);
            chk_others(r);
        end
        chk(rank_pwr[2*r +: 2] == 2'b00, "R8", "idle power after refresh", int'(rank_pwr[2*r +: 2]), 0);
        if (owe) begin
            step();
            chk(rank_avail[r] == 1'b0, "R9", "remembered refresh starts", int'(rank_avail[r]), 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        chk(rank_avail == '1, "R10", "avail after reset", int'(rank_avail), 15);
        chk(cmd_valid == 1'b0, "R10", "valid after reset", int'(cmd_valid), 0);
        chk(rank_pwr == '0, "R8", "idle power after reset", int'(rank_pwr), 0);
        bank_open[3*NB] = 1'b1;
        #1;
        chk(rank_pwr[7:6] == 2'b01, "R8", "active power with open bank", int'(rank_pwr[7:6]), 1);
        bank_open = '0;
        #1;
        chk(rank_pwr[7:6] == 2'b00, "R8", "idle power all closed", int'(rank_pwr[7:6]), 0);

        // Sweep every open-bank pattern of rank 1
        for (int m = 0; m < (1 << NB); m++) begin
            bank_open[1*NB +: NB] = NB'(m);
            run_ticks(1);
            finish_refresh(1, NB'(m), 1'b0);
            step();
        end

        // Expiry during a refresh: two refreshes back to back on rank 0
        bank_open[0 +: NB] = 4'b1001;
        run_ticks(0);
        finish_refresh(0, 4'b1001, 1'b1);
        finish_refresh(0, '0, 1'b0);
        step();

        // Ranks 2 and 3 expire together with the bus stalled
        cmd_ready = 1'b0;
        for (int k = 0; k < REFI; k++) begin
            ref_tick[3:2] = 2'b11;
            step();
        end
        ref_tick = '0;
        step();
        for (int w = 0; w < 3; w++) begin
            chk(cmd_valid == 1'b1, "R7", "request held while stalled", int'(cmd_valid), 1);
            chk(int'(cmd_rank) == 2, "R7", "lowest rank wins", int'(cmd_rank), 2);
            step();
        end
        cmd_ready = 1'b1;
        step();
        chk(cmd_valid && int'(cmd_rank) == 3, "R7", "next rank served", int'(cmd_rank), 3);
        step();
        chk(cmd_valid == 1'b0, "R7", "bus idle after both", int'(cmd_valid), 0);
        for (int i = 2; i <= TRFC; i++) step();
        chk(rank_avail[2] == 1'b1, "R5", "rank 2 back", int'(rank_avail[2]), 1);
        chk(rank_avail[3] == 1'b0, "R5", "rank 3 still busy", int'(rank_avail[3]), 0);
        step();
        chk(rank_avail[3] == 1'b1, "R5", "rank 3 back", int'(rank_avail[3]), 1);
        chk(rank_avail[1:0] == 2'b11, "R6", "ranks 0 and 1 untouched", int'(rank_avail[1:0]), 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule